// File: doc/BRIEF.md
# SPD timing field to clock converter

This block takes one timing parameter from a memory module's serial presence table and turns it into a whole number of memory controller clocks. The caller gives the memory generation (DDR1 or DDR2), the raw parameter byte, the low bits of an extension byte, a code for the kind of field, and the controller clock period in picoseconds. The block decodes the field into picoseconds and divides by the period, rounding any fraction up to a whole clock.

A one-cycle `start` pulse begins a conversion. The picosecond value is available on `ps_out` from the cycle after `start` is accepted. A restoring divider then produces one quotient bit per cycle. `done` pulses for one cycle when `clk_count` is valid. A zero period cannot be divided, so it is reported through `err` at once. Firmware-style setup logic can run one field after another through the same block.

Top module: `spd_clk_conv`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and `ps_out` and `clk_count` are zero.
- R2: For field kind 0 (cycle time), the raw byte is decoded as follows. The upper nibble gives whole nanoseconds at 1000 ps each. The lower nibble adds 0 to 900 ps in 100 ps steps for codes 0 to 9, adds 250, 330, 660 or 750 ps for codes 10, 11, 12 or 13, and adds 0 for codes 14 and 15.
- R3: For field kind 1 (quarter-nanosecond delays), the picosecond value is the raw byte times 250.
- R4: For field kind 2 (row active time), the picosecond value is the raw byte times 1000.
- R5: For field kind 3 (refresh recovery) with `is_ddr2` low, the picosecond value is the raw byte times 1000, and `ext` has no effect.
- R6: For field kind 3 with `is_ddr2` high, the picosecond value is (`ext[0]`·256 + raw)·1000 plus a fraction chosen by `ext[3:1]`. Codes 0 to 5 give 0, 250, 330, 500, 660 and 750 ps; codes 6 and 7 give 0.
- R7: Field kinds 4 to 7 give a picosecond value of 0 and a clock count of 0.
- R8: With a nonzero period, `clk_count` is the smallest whole number of periods that is at least `ps_out`.
- R9: A zero period makes `done` and `err` rise together one cycle after `start` is accepted, with `clk_count` zero.
- R10: With a nonzero period, `busy` is high while the divider runs. `done` rises exactly 20 cycles after the accepting edge (`PS_W`), lasts one cycle, and `busy` is low with it.
- R11: A `start` while `busy` is high, including in the final divider cycle, is ignored. It leaves `ps_out` and `clk_count` unchanged and produces no extra `done`.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion when idle |
| is_ddr2 | input | 1 | 1 for DDR2 field rules, 0 for DDR1 |
| kind | input | 3 | Field kind: 0 cycle time, 1 quarter-ns, 2 row active, 3 refresh recovery |
| raw | input | 8 | Raw parameter byte |
| ext | input | 4 | Low bits of the extension byte used by DDR2 refresh recovery |
| period_ps | input | 16 | Controller clock period in picoseconds |
| busy | output | 1 | Divider is running |
| done | output | 1 | One-cycle pulse when the result is valid |
| err | output | 1 | The last conversion had a zero period |
| ps_out | output | 20 | Decoded parameter in picoseconds |
| clk_count | output | 20 | Parameter rounded up to whole clocks |

## Verification
The case that matters most is a new `start` arriving in the same cycle as the divider's last step, when `done` is about to fire. The bench raises `start`, with a different byte and period, so that it is sampled at exactly the edge that completes the division. It then checks three things: the reported count belongs to the first request, `ps_out` keeps its value, and no second `done` appears over the following cycles. A second overlap case also comes up: a zero-period conversion accepted right after a normal one puts `done` and `err` in the same cycle, and that result is judged against R9.

// File: rtl/spd_clk_conv.sv
module spd_clk_conv #(
  parameter int PERIOD_W = 16,
  parameter int PS_W     = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                is_ddr2,
  input  logic [2:0]          kind,
  input  logic [7:0]          raw,
  input  logic [3:0]          ext,
  input  logic [PERIOD_W-1:0] period_ps,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [PS_W-1:0]     ps_out,
  output logic [PS_W-1:0]     clk_count
);
  localparam int REM_W  = PERIOD_W + 1;
  localparam int STEP_W = $clog2(PS_W);

  function automatic logic [9:0] tenth_ps(input logic [3:0] n);
    case (n)
      4'd10:   return 10'd250;
      4'd11:   return 10'd330;
      4'd12:   return 10'd660;
      4'd13:   return 10'd750;
      4'd14,
      4'd15:   return 10'd0;
      default: return 10'(n) * 10'd100;
    endcase
  endfunction

  function automatic logic [9:0] frac_ps(input logic [2:0] s);
    case (s)
      3'd1:    return 10'd250;
      3'd2:    return 10'd330;
      3'd3:    return 10'd500;
      3'd4:    return 10'd660;
      3'd5:    return 10'd750;
      default: return 10'd0;
    endcase
  endfunction

  logic [PS_W-1:0] ps_in;

  always_comb begin
    case (kind)
      3'd0: ps_in = PS_W'(raw[7:4]) * PS_W'(1000) + PS_W'(tenth_ps(raw[3:0]));
      3'd1: ps_in = PS_W'(raw) * PS_W'(250);
      3'd2: ps_in = PS_W'(raw) * PS_W'(1000);
      3'd3: ps_in = is_ddr2 ? PS_W'({ext[0], raw}) * PS_W'(1000) + PS_W'(frac_ps(ext[3:1]))
                            : PS_W'(raw) * PS_W'(1000);
      default: ps_in = '0;
    endcase
  end

  logic [PERIOD_W-1:0] div_q;
  logic [PERIOD_W-1:0] rem_q;
  logic [PS_W-1:0]     dq_q;
  logic [STEP_W-1:0]   step_q;

  logic [REM_W-1:0] trial, rem_nx;
  logic             fits;
  logic [PS_W-1:0]  dq_nx;

  assign trial  = {rem_q, dq_q[PS_W-1]};
  assign fits   = trial >= {1'b0, div_q};
  assign rem_nx = fits ? trial - {1'b0, div_q} : trial;
  assign dq_nx  = {dq_q[PS_W-2:0], fits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      ps_out    <= '0;
      clk_count <= '0;
      div_q     <= '0;
      rem_q     <= '0;
      dq_q      <= '0;
      step_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          ps_out <= ps_in;
          if (period_ps == '0) begin
            done      <= 1'b1;
            err       <= 1'b1;
            clk_count <= '0;
          end else begin
            err    <= 1'b0;
            busy   <= 1'b1;
            div_q  <= period_ps;
            rem_q  <= '0;
            dq_q   <= ps_in;
            step_q <= '0;
          end
        end
      end else begin
        rem_q  <= rem_nx[PERIOD_W-1:0];
        dq_q   <= dq_nx;
        step_q <= step_q + 1'b1;
        if (step_q == STEP_W'(PS_W - 1)) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          clk_count <= dq_nx + PS_W'(rem_nx != '0);
        end
      end
    end
  end
endmodule

// File: rtl/spd_clk_conv_chk.sv
module spd_clk_conv_chk #(
  parameter int PERIOD_W = 16,
  parameter int PS_W     = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [PERIOD_W-1:0] period_ps,
  input logic                busy,
  input logic                done,
  input logic                err,
  input logic [PS_W-1:0]     ps_out,
  input logic [PS_W-1:0]     clk_count
);
  localparam int PW2 = PS_W + PERIOD_W + 1;

  logic [PERIOD_W-1:0] per_q;
  int unsigned         lat_q;
  logic [PW2-1:0]      prod, lim_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      lat_q <= 0;
    end else if (start && !busy) begin
      per_q <= period_ps;
      lat_q <= 0;
    end else if (lat_q < 1000) begin
      lat_q <= lat_q + 1;
    end
  end

  assign prod   = PW2'(clk_count) * PW2'(per_q);
  assign lim_hi = PW2'(ps_out) + PW2'(per_q);

  assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (prod >= PW2'(ps_out)) && (prod < lim_hi));

  assert_zero_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (clk_count == '0));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (lat_q == PS_W));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || err));

  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ps_out));
endmodule

bind spd_clk_conv spd_clk_conv_chk #(.PERIOD_W(PERIOD_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
  .busy(busy), .done(done), .err(err), .ps_out(ps_out), .clk_count(clk_count)
);

// File: tb/spd_clk_conv_bench.sv
module spd_clk_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_ddr2 = 1'b0;
  logic [2:0]  kind = '0;
  logic [7:0]  raw = '0;
  logic [3:0]  ext = '0;
  logic [15:0] period_ps = '0;
  logic        busy, done, err;
  logic [19:0] ps_out, clk_count;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  spd_clk_conv u_spd_clk_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .is_ddr2(is_ddr2), .kind(kind),
    .raw(raw), .ext(ext), .period_ps(period_ps), .busy(busy), .done(done),
    .err(err), .ps_out(ps_out), .clk_count(clk_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_ps(input bit d2, input int k, input int r, input int e);
    int lo, fr;
    if (k == 0) begin
      lo = r % 16;
      if (lo < 10) fr = lo * 100;
      else if (lo == 10) fr = 250;
      else if (lo == 11) fr = 330;
      else if (lo == 12) fr = 660;
      else if (lo == 13) fr = 750;
      else fr = 0;
      return (r / 16) * 1000 + fr;
    end
    if (k == 1) return r * 250;
    if (k == 2) return r * 1000;
    if (k == 3) begin
      if (!d2) return r * 1000;
      case ((e / 2) % 8)
        1: fr = 250;
        2: fr = 330;
        3: fr = 500;
        4: fr = 660;
        5: fr = 750;
        default: fr = 0;
      endcase
      return ((e % 2) * 256 + r) * 1000 + fr;
    end
    return 0;
  endfunction

  // inter: negedge index at which a stray start is raised while busy (-1 none)
  task automatic run_op(input string tag, input bit d2, input int k, input int r,
                        input int e, input int per, input int inter);
    int exp_ps, exp_cnt, lat;
    exp_ps  = model_ps(d2, k, r, e);
    exp_cnt = (per == 0) ? 0 : (exp_ps + per - 1) / per;
    @(negedge clk);
    is_ddr2 = d2; kind = 3'(k); raw = 8'(r); ext = 4'(e); period_ps = 16'(per);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1;
    if (done) lat = 0;
    for (int i = 1; i <= 40 && lat < 0; i++) begin
      if (i - 1 == inter) begin
        start = 1'b1; raw = ~raw; period_ps = period_ps + 16'd7;
      end
      @(negedge clk);
      start = 1'b0;
      if (done) lat = i;
    end
    chk({tag, " R10 latency"}, lat, (per == 0) ? 0 : 20);
    chk({tag, " ps"}, int'(ps_out), exp_ps);
    chk({tag, " R8 count"}, int'(clk_count), exp_cnt);
    chk({tag, " R9 err"}, int'(err), (per == 0) ? 1 : 0);
    chk({tag, " R10 busy low at done"}, int'(busy), 0);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, int'(done), 0);
    if (inter >= 0) begin
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (done) chk({tag, " R11 no extra done"}, 1, 0);
      end
      chk({tag, " R11 ps kept"}, int'(ps_out), exp_ps);
      chk({tag, " R11 count kept"}, int'(clk_count), exp_cnt);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 ps_out", int'(ps_out), 0);
    chk("R1 clk_count", int'(clk_count), 0);
  endtask

  task automatic t_cycle_time;
    run_op("R2 3.75ns", 1'b1, 0, 8'h3D, 0, 1875, -1);
    run_op("R2 2.5ns", 1'b0, 0, 8'h25, 0, 3000, -1);
    run_op("R2 10.33ns", 1'b0, 0, 8'hAB, 0, 5000, -1);
    run_op("R2 code14", 1'b1, 0, 8'hFE, 0, 4000, -1);
    run_op("R2 code12", 1'b1, 0, 8'h7C, 0, 1, -1);
  endtask

  task automatic t_quarter;
    run_op("R3 exact", 1'b1, 1, 60, 0, 2500, -1);
    run_op("R3 round", 1'b1, 1, 61, 0, 2500, -1);
  endtask

  task automatic t_tras;
    run_op("R4 tras", 1'b0, 2, 45, 0, 7500, -1);
  endtask

  task automatic t_refresh;
    run_op("R5 ddr1", 1'b0, 3, 105, 0, 3000, -1);
    run_op("R5 ddr1 ext ignored", 1'b0, 3, 105, 4'hF, 3000, -1);
    run_op("R6 ddr2 ext7", 1'b1, 3, 8'h2C, 4'h7, 3750, -1);
    run_op("R6 ddr2 code6", 1'b1, 3, 8'hFF, 4'hD, 65535, -1);
    run_op("R6 ddr2 code2", 1'b1, 3, 127, 4'h4, 2500, -1);
  endtask

  task automatic t_unused_kind;
    run_op("R7 kind5", 1'b1, 5, 8'hFF, 4'hF, 3000, -1);
  endtask

  task automatic t_zero_period;
    run_op("R9 zero period", 1'b1, 1, 40, 0, 0, -1);
    run_op("R9 recovers", 1'b1, 1, 40, 0, 3000, -1);
  endtask

  task automatic t_busy_start;
    run_op("R11 mid", 1'b1, 1, 99, 0, 2500, 5);
    run_op("R11 final step", 1'b1, 2, 77, 0, 3300, 19);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_cycle_time();
    t_quarter();
    t_tras();
    t_refresh();
    t_unused_kind();
    t_zero_period();
    t_busy_start();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule